// File: doc/BRIEF.md
# Display Controller Command Decoder

This block sits behind the host interface of a dot-matrix panel controller and turns the stream of received bytes into configuration state. Each byte arrives with a valid strobe and a flag that marks it as display data or as a command. A command byte either takes effect at once, or it opens a two-byte command whose next command byte is its argument. The decoded settings are held in registers and drive the scan and segment logic elsewhere in the chip. These settings are display enable, first scanned line, brightness, segment and row orientation, the multiplex ratio, the vertical offset, page and column pointers, the all-pixels-on and inverse modes, the clock divider, colour-area mode and row-pin wiring.

Display-data bytes do not go to the display memory here. They only advance the column pointer, so that the memory write logic always receives the address of the next byte. The pointer wraps at the panel width and leaves the page pointer alone.

Top module: `panel_cmd_decoder`

## Requirements
- R1: After reset the registers hold these values: display off, first line 0, column 0, page 0, segment remap off, row scan normal, brightness 0x80, multiplex ratio 63, offset 0, all-pixels-on off, inverse off, clock divider 0x00, colour-area 0 and row-pin config 0.
- R2: A command byte of the form 01xxxxxx loads its low 6 bits into the first-line register.
- R3: A command byte 0000xxxx loads bits 3:0 of the column pointer, and 0001xxxx loads bits 7:4. The other bits of the column pointer are kept.
- R4: A command byte 1011xxxx loads its low 3 bits into the page pointer, which covers 8 pages.
- R5: The one-byte flag commands act as follows. Bit 0 of 0xA0/0xA1 sets segment remap, bit 0 of 0xA4/0xA5 sets all-pixels-on, bit 0 of 0xA6/0xA7 sets inverse, and bit 0 of 0xAE/0xAF sets display enable. Any byte 0xC0 to 0xCF sets the row-scan reverse flag from its bit 3.
- R6: A two-byte opcode leaves its register unchanged until the argument arrives, and then stores only the meaningful bits of that argument. 0x81 stores 8 bits as brightness, 0xA8 stores bits 5:0 as the multiplex ratio, 0xD3 stores bits 5:0 as the offset and 0xD5 stores 8 bits as the clock divider. 0xD8 stores bits 5:4 as colour-area and 0xDA stores bit 4 as row-pin config.
- R7: The command byte that follows a two-byte opcode is taken as its argument whatever its value, and it is not decoded as a command.
- R8: Each data byte increments the column pointer. From 131 or any larger value the pointer goes to 0, and the page pointer does not change.
- R9: Data bytes that arrive between a two-byte opcode and its argument advance the column pointer but neither supply nor cancel the argument.
- R10: An unrecognised command byte changes no register and leaves no argument pending, so the next command byte is decoded normally.
- R11: A byte presented while the valid strobe is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | Strobe: byte_in is taken on this cycle |
| byte_is_data | input | 1 | 1 = display data, 0 = command |
| byte_in | input | 8 | Received byte |
| disp_on | output | 1 | Display enable |
| start_line | output | 6 | First scanned line |
| contrast | output | 8 | Brightness level |
| seg_remap | output | 1 | Segment order reversed |
| scan_reverse | output | 1 | Row scan direction reversed |
| mux_ratio | output | 6 | Multiplex ratio minus one |
| disp_offset | output | 6 | Vertical offset |
| page_addr | output | 3 | Page pointer |
| col_addr | output | 8 | Column pointer |
| all_pixels_on | output | 1 | Force every pixel lit |
| invert | output | 1 | Inverse display |
| clk_div | output | 8 | Clock divider / oscillator setting |
| area_colour | output | 2 | Colour-area mode bits |
| row_pin_alt | output | 1 | Alternative row-pin wiring |

## Verification
The bench sends an argument byte that is itself a valid opcode (0xAF after 0x81). A decoder that checks the opcode table before the pending state would switch the display on instead of loading the brightness. It drives the column pointer to 130, to 131 and to 255 and then writes data. An off-by-one wrap would show up as 132 or a stuck pointer, and a carry into the page would change the page value. It also puts data bytes between an opcode and its argument, then sends an unknown opcode followed by a one-byte command. A design that lets data clear the pending state, or lets an unknown opcode arm one, would lose the multiplex setting or swallow the display-on command.

// File: rtl/panel_cmd_pkg.sv
package panel_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_START, OP_COL_LO, OP_COL_HI, OP_PAGE,
    OP_REMAP, OP_SCAN, OP_ENTIRE, OP_INVERT, OP_DISPON, OP_TWO
  } op_kind_e;

  typedef enum logic [2:0] {
    ARG_NONE, ARG_CONTRAST, ARG_MUX, ARG_OFFSET, ARG_CLKDIV, ARG_AREA, ARG_PINS
  } arg_kind_e;

  typedef struct packed {
    op_kind_e  kind;
    arg_kind_e arg;
  } op_decode_t;

  // Opcode table: one-byte patterns first, then exact two-byte openers.
  function automatic op_decode_t decode_opcode(input logic [7:0] b);
    op_decode_t d;
    d.kind = OP_NONE;
    d.arg  = ARG_NONE;
    casez (b)
      8'b01??????: d.kind = OP_START;
      8'b0000????: d.kind = OP_COL_LO;
      8'b0001????: d.kind = OP_COL_HI;
      8'b1011????: d.kind = OP_PAGE;
      8'b1100????: d.kind = OP_SCAN;
      8'b1010000?: d.kind = OP_REMAP;
      8'b1010010?: d.kind = OP_ENTIRE;
      8'b1010011?: d.kind = OP_INVERT;
      8'b1010111?: d.kind = OP_DISPON;
      8'h81: begin d.kind = OP_TWO; d.arg = ARG_CONTRAST; end
      8'hA8: begin d.kind = OP_TWO; d.arg = ARG_MUX;      end
      8'hD3: begin d.kind = OP_TWO; d.arg = ARG_OFFSET;   end
      8'hD5: begin d.kind = OP_TWO; d.arg = ARG_CLKDIV;   end
      8'hD8: begin d.kind = OP_TWO; d.arg = ARG_AREA;     end
      8'hDA: begin d.kind = OP_TWO; d.arg = ARG_PINS;     end
      default: ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/panel_cmd_classify.sv
module panel_cmd_classify
  import panel_cmd_pkg::*;
(
  input  logic [7:0] byte_in,
  output op_decode_t dec
);
  always_comb dec = decode_opcode(byte_in);
endmodule

// File: rtl/panel_col_counter.sv
module panel_col_counter #(
  parameter int unsigned NUM_COLS = 132,
  parameter int unsigned COL_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_lo,
  input  logic             set_hi,
  input  logic [3:0]       nibble,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic             wrap
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

  function automatic logic [COL_W-1:0] advance(input logic [COL_W-1:0] c);
    return (c >= LAST_COL) ? '0 : c + 1'b1;
  endfunction

  assign wrap = step && (col >= LAST_COL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
    end else if (step) begin
      col <= advance(col);
    end else if (set_lo) begin
      col[3:0] <= nibble;
    end else if (set_hi) begin
      col[7:4] <= nibble;
    end
  end

  assert_col_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (col == '0));
  assert_col_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wrap) |=> (col == $past(col) + 1'b1));
  assert_col_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !set_lo && !set_hi) |=> $stable(col));
endmodule

// File: rtl/panel_cmd_decoder.sv
module panel_cmd_decoder
  import panel_cmd_pkg::*;
#(
  parameter int unsigned NUM_COLS     = 132,
  parameter int unsigned NUM_ROWS     = 64,
  parameter int unsigned ROWS_PER_PG  = 8,
  parameter logic [7:0]  CONTRAST_RST = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic       byte_is_data,
  input  logic [7:0] byte_in,
  output logic       disp_on,
  output logic [5:0] start_line,
  output logic [7:0] contrast,
  output logic       seg_remap,
  output logic       scan_reverse,
  output logic [5:0] mux_ratio,
  output logic [5:0] disp_offset,
  output logic [2:0] page_addr,
  output logic [7:0] col_addr,
  output logic       all_pixels_on,
  output logic       invert,
  output logic [7:0] clk_div,
  output logic [1:0] area_colour,
  output logic       row_pin_alt
);
  localparam int unsigned ROW_W = $clog2(NUM_ROWS);
  localparam int unsigned PG_W  = $clog2(NUM_ROWS / ROWS_PER_PG);
  localparam int unsigned COL_W = ($clog2(NUM_COLS) > 8) ? $clog2(NUM_COLS) : 8;
  localparam logic [ROW_W-1:0] MUX_RST = ROW_W'(NUM_ROWS - 1);

  // Named events for the assertions
  logic       cmd_fire, data_fire, arg_fire, op_fire, col_wrap;
  arg_kind_e  pending;
  op_decode_t dec;
  logic [COL_W-1:0] col_full;

  assign cmd_fire  = byte_valid && !byte_is_data;
  assign data_fire = byte_valid &&  byte_is_data;
  assign arg_fire  = cmd_fire && (pending != ARG_NONE);
  assign op_fire   = cmd_fire && (pending == ARG_NONE);

  panel_cmd_classify u_classify (
    .byte_in (byte_in),
    .dec     (dec)
  );

  panel_col_counter #(.NUM_COLS(NUM_COLS), .COL_W(COL_W)) u_col (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_lo (op_fire && dec.kind == OP_COL_LO),
    .set_hi (op_fire && dec.kind == OP_COL_HI),
    .nibble (byte_in[3:0]),
    .step   (data_fire),
    .col    (col_full),
    .wrap   (col_wrap)
  );
  assign col_addr = col_full[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending       <= ARG_NONE;
      disp_on       <= 1'b0;
      start_line    <= '0;
      contrast      <= CONTRAST_RST;
      seg_remap     <= 1'b0;
      scan_reverse  <= 1'b0;
      mux_ratio     <= MUX_RST;
      disp_offset   <= '0;
      page_addr     <= '0;
      all_pixels_on <= 1'b0;
      invert        <= 1'b0;
      clk_div       <= '0;
      area_colour   <= '0;
      row_pin_alt   <= 1'b0;
    end else if (arg_fire) begin
      pending <= ARG_NONE;
      unique case (pending)
        ARG_CONTRAST: contrast    <= byte_in;
        ARG_MUX:      mux_ratio   <= byte_in[ROW_W-1:0];
        ARG_OFFSET:   disp_offset <= byte_in[ROW_W-1:0];
        ARG_CLKDIV:   clk_div     <= byte_in;
        ARG_AREA:     area_colour <= byte_in[5:4];
        ARG_PINS:     row_pin_alt <= byte_in[4];
        default: ;
      endcase
    end else if (op_fire) begin
      case (dec.kind)
        OP_START:  start_line    <= byte_in[ROW_W-1:0];
        OP_PAGE:   page_addr     <= byte_in[PG_W-1:0];
        OP_REMAP:  seg_remap     <= byte_in[0];
        OP_SCAN:   scan_reverse  <= byte_in[3];
        OP_ENTIRE: all_pixels_on <= byte_in[0];
        OP_INVERT: invert        <= byte_in[0];
        OP_DISPON: disp_on       <= byte_in[0];
        OP_TWO:    pending       <= dec.arg;
        default: ;
      endcase
    end
  end

  assert_arg_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arg_fire |=> (pending == ARG_NONE));
  assert_arg_contrast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arg_fire && pending == ARG_CONTRAST) |=> (contrast == $past(byte_in)));
  assert_data_keeps_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |=> (pending == $past(pending)));
  assert_data_keeps_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |=> $stable(page_addr));
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> ($stable(disp_on) && $stable(contrast) && $stable(pending)));
  assert_unknown_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && dec.kind == OP_NONE) |=> (pending == ARG_NONE && $stable(disp_on)));
endmodule

// File: tb/test_panel_cmd_decoder.sv
`timescale 1ns/1ps
module test_panel_cmd_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0, byte_is_data = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic disp_on, seg_remap, scan_reverse, all_pixels_on, invert, row_pin_alt;
  logic [5:0] start_line, mux_ratio, disp_offset;
  logic [7:0] contrast, col_addr, clk_div;
  logic [2:0] page_addr;
  logic [1:0] area_colour;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  panel_cmd_decoder i_panel_cmd_decoder (
    .clk, .rst_n, .byte_valid, .byte_is_data, .byte_in,
    .disp_on, .start_line, .contrast, .seg_remap, .scan_reverse,
    .mux_ratio, .disp_offset, .page_addr, .col_addr, .all_pixels_on,
    .invert, .clk_div, .area_colour, .row_pin_alt
  );

  // Field selectors: 0 start,1 on,2 remap,3 scan,4 all-on,5 inv,6 page,
  // 7 col,8 contrast,9 mux,10 offset,11 clkdiv,12 area,13 pins
  function automatic logic [7:0] field(input int sel);
    case (sel)
      0: return {2'b0, start_line};
      1: return {7'b0, disp_on};
      2: return {7'b0, seg_remap};
      3: return {7'b0, scan_reverse};
      4: return {7'b0, all_pixels_on};
      5: return {7'b0, invert};
      6: return {5'b0, page_addr};
      7: return col_addr;
      8: return contrast;
      9: return {2'b0, mux_ratio};
      10: return {2'b0, disp_offset};
      11: return clk_div;
      12: return {6'b0, area_colour};
      default: return {7'b0, row_pin_alt};
    endcase
  endfunction

  task automatic check(input string req, input int sel, input logic [7:0] exp);
    checks++;
    if (field(sel) !== exp) begin
      failures++;
      $display("FAIL %s field %0d actual=%0h expected=%0h", req, sel, field(sel), exp);
    end
  endtask

  task automatic send(input logic is_data, input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1; byte_is_data = is_data; byte_in = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  // {is_data, byte, selector, expected}
  localparam int NV = 25;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 8'h41, 4'd0,  8'd1},    // R2
    {1'b0, 8'h7F, 4'd0,  8'd63},   // R2
    {1'b0, 8'hAF, 4'd1,  8'd1},    // R5
    {1'b0, 8'hAE, 4'd1,  8'd0},    // R5
    {1'b0, 8'hA1, 4'd2,  8'd1},    // R5
    {1'b0, 8'hC8, 4'd3,  8'd1},    // R5
    {1'b0, 8'hC7, 4'd3,  8'd0},    // R5
    {1'b0, 8'hA5, 4'd4,  8'd1},    // R5
    {1'b0, 8'hA7, 4'd5,  8'd1},    // R5
    {1'b0, 8'hB5, 4'd6,  8'd5},    // R4
    {1'b0, 8'h03, 4'd7,  8'd3},    // R3
    {1'b0, 8'h17, 4'd7,  8'h73},   // R3
    {1'b0, 8'h81, 4'd8,  8'h80},   // R6 held
    {1'b0, 8'h3C, 4'd8,  8'h3C},   // R6
    {1'b0, 8'hA8, 4'd9,  8'd63},   // R6 held
    {1'b0, 8'hDF, 4'd9,  8'd31},   // R6 low 6 bits
    {1'b0, 8'hD3, 4'd10, 8'd0},    // R6
    {1'b0, 8'h48, 4'd10, 8'd8},    // R6
    {1'b0, 8'hD5, 4'd11, 8'h00},   // R6
    {1'b0, 8'hF0, 4'd11, 8'hF0},   // R6
    {1'b0, 8'hD8, 4'd12, 8'd0},    // R6
    {1'b0, 8'h30, 4'd12, 8'd3},    // R6
    {1'b0, 8'hDA, 4'd13, 8'd0},    // R6
    {1'b0, 8'h12, 4'd13, 8'd1},    // R6
    {1'b1, 8'hAA, 4'd7,  8'd116}   // R8
  };

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    check("R1", 1, 0);  check("R1", 0, 0);  check("R1", 7, 0);
    check("R1", 6, 0);  check("R1", 2, 0);  check("R1", 3, 0);
    check("R1", 8, 8'h80); check("R1", 9, 63); check("R1", 10, 0);
    check("R1", 4, 0);  check("R1", 5, 0);  check("R1", 11, 0);
    check("R1", 12, 0); check("R1", 13, 0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][20], VEC[i][19:12]);
      check("table", int'(VEC[i][11:8]), VEC[i][7:0]);
    end

    // R8: wrap at 131, page unchanged
    send(0, 8'h02); send(0, 8'h18);
    check("R3", 7, 8'd130);
    send(1, 8'h00); check("R8", 7, 8'd131);
    send(1, 8'h00); check("R8", 7, 8'd0);
    check("R8", 6, 8'd5);
    // R8: beyond the last column also wraps
    send(0, 8'h0F); send(0, 8'h1F);
    check("R3", 7, 8'hFF);
    send(1, 8'h11); check("R8", 7, 8'd0);

    // R7: argument equal to an opcode is not decoded
    send(0, 8'h81); send(0, 8'hAF);
    check("R7", 8, 8'hAF);
    check("R7", 1, 8'd0);

    // R9: data between opcode and argument
    send(0, 8'hA8);
    send(1, 8'h55); check("R9", 7, 8'd1);
    check("R9", 9, 8'd31);
    send(0, 8'h2A); check("R9", 9, 8'd42);

    // R10: unknown opcode arms nothing, changes nothing
    send(0, 8'hE3);
    check("R10", 8, 8'hAF);
    check("R10", 7, 8'd1);
    send(0, 8'hAF); check("R10", 1, 8'd1);

    // R11: strobe low
    @(negedge clk);
    byte_is_data = 1'b0; byte_in = 8'hAE;
    @(negedge clk);
    check("R11", 1, 8'd1);
    byte_is_data = 1'b1;
    @(negedge clk);
    check("R11", 7, 8'd1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule